// File: doc/BRIEF.md
# System Global Control Register Bank

This block holds the chip's global control and status words in a 4 KiB address window. A bus master reaches it through a single-cycle request/response port. A request gives a byte address, a write flag, an access size and up to 64 bits of write data. One cycle later the block answers with registered read data and an error flag. The word index is the byte address shifted right by two, and words are stored little-endian.

Each word follows one of four write behaviours. A plain word takes the written value. A read-only word ignores the write and flags it. A clear-on-one word drops every bit written as 1. A set-on-one word keeps every bit it already holds and adds the bits written as 1.

Above the scratchpad base, 64-bit paired accesses are also allowed. They move two adjacent words at once and apply no per-word behaviour. Reset loads fixed cold values, two strap inputs, and a DRAM-size code derived from a parameter. That parameter is checked at elaboration.

Top module: `gcr_regbank`

## Requirements
- R1: The response is registered. On the first cycle after reset, `rsp_valid` is 0. Reads return the cold values: word 0x000 = 0x04A35850, 0x014 = 0x0000FFFF, 0x06C = 0x80000000, 0x060 = 0x00080000, 0x13C = 0x00000008, and 0x140, 0x144 and 0x148 = 0x034730E4.
- R2: An access at or beyond offset 0xF80 (word index ≥ 992) returns `rsp_err` = 1 and read data 0. A write there changes no word.
- R3: Words 0x000, 0x004 and 0x040 are read-only. A 32-bit write to one of them sets `rsp_err` and leaves the word unchanged.
- R4: Words 0x06C and 0x0D4 are clear-on-one: new = old AND NOT data.
- R5: Words 0x070 and 0x07C are set-on-one: new = old OR data. Software cannot clear a bit in them.
- R6: Every other implemented word stores the written 32-bit value as is, and reads it back.
- R7: A 64-bit access (`req_size` = 3) to an 8-byte-aligned offset from 0xE00 up to 0xF78 reaches word n in bits 31:0 and word n+1 in bits 63:32. A 64-bit write stores both halves unchanged.
- R8: A 64-bit access below 0xE00, at an odd word index, or at 0xF7C is rejected with `rsp_err` = 1 and has no effect.
- R9: Byte (`req_size` = 0) and half-word (`req_size` = 1) accesses, and 32-bit accesses whose address bits 1:0 are not 0, are rejected with `rsp_err` = 1 and have no effect.
- R10: Reset loads word 0x004 from `strap_pwr` and word 0x07C from `strap_mdis`.
- R11: Reset loads word 0x09C with 0x00001002 OR (log2(DRAM_BYTES / 128 MiB) << 8), and word 0x084 with the low 32 bits of DRAM_BYTES. At the default of 2 GiB these are 0x00001402 and 0x80000000.
- R12: Reset sets the 32 semaphore words at 0xF00 to 0xF7C to 1 and the scratchpad words at 0xE00 to 0xEFC to 0.
- R13: `rsp_valid` rises exactly one cycle after each accepted `req_valid` and is 0 otherwise. A read issued in the cycle after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads cold and strap values |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| req_wdata | input | 64 | Write data, bits 31:0 used for a word |
| strap_pwr | input | 32 | Power-on strap value captured at reset |
| strap_mdis | input | 32 | Module-disable value captured at reset |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 64 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Access rejected or read-only write |

## Verification
Every response, both read data and error, is due on the first rising edge after the request. A write becomes visible to a read issued in the very next cycle. The bench drives requests on the falling edge. On every following falling edge it compares `rsp_valid`, `rsp_err` and `rsp_rdata` against a behavioural word model, which it updates at the same moment. Idle cycles are compared as well, so any response that arrives a cycle early or late, or without a request, is caught. The checks use back-to-back write/read pairs to show that the store sits only one register deep.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    typedef enum logic [1:0] {
        POL_RW  = 2'd0,
        POL_RO  = 2'd1,
        POL_W1C = 2'd2,
        POL_W1S = 2'd3
    } wpol_e;

    typedef struct packed {
        logic        vld;
        logic        err;
        logic [63:0] rdata;
    } rsp_t;

    // word indices whose position software relies on
    localparam int IX_PROD_ID   = 0;
    localparam int IX_STRAPS    = 1;
    localparam int IX_PULL_EN   = 5;
    localparam int IX_CORE_MODE = 13;
    localparam int IX_SPARE_SW  = 14;
    localparam int IX_INT_CTL   = 15;
    localparam int IX_INT_STAT  = 16;
    localparam int IX_HOST_IF   = 20;
    localparam int IX_INT_CTL2  = 24;
    localparam int IX_RST_STAT  = 27;
    localparam int IX_RST_LOCK  = 28;
    localparam int IX_MOD_DIS   = 31;
    localparam int IX_SCR_DRAM  = 33;
    localparam int IX_VOLT_LVL  = 38;
    localparam int IX_INT_CTL3  = 39;
    localparam int IX_SD_UP1    = 45;
    localparam int IX_SD_UP2    = 46;
    localparam int IX_CP_STAT   = 53;
    localparam int IX_VSRC      = 58;
    localparam int IX_SCR_MISC  = 79;
    localparam int IX_USB_PHY   = 80;
    localparam int USB_PHY_CNT  = 3;
    localparam int IX_SCRATCH   = 896;
    localparam int IX_SEM       = 960;
    localparam int SEM_CNT      = 32;

    function automatic wpol_e word_policy(input int idx);
        case (idx)
            IX_PROD_ID, IX_STRAPS, IX_INT_STAT: return POL_RO;
            IX_RST_STAT, IX_CP_STAT:            return POL_W1C;
            IX_RST_LOCK, IX_MOD_DIS:            return POL_W1S;
            default:                            return POL_RW;
        endcase
    endfunction

    function automatic logic [31:0] cold_word(
        input int          idx,
        input logic [31:0] pwr,
        input logic [31:0] mdis,
        input logic [31:0] ctl3,
        input logic [31:0] dram
    );
        if (idx >= IX_SEM && idx < IX_SEM + SEM_CNT) return 32'h0000_0001;
        if (idx >= IX_USB_PHY && idx < IX_USB_PHY + USB_PHY_CNT) return 32'h0347_30E4;
        case (idx)
            IX_STRAPS:    return pwr;
            IX_MOD_DIS:   return mdis;
            IX_INT_CTL3:  return ctl3;
            IX_SCR_DRAM:  return dram;
            IX_PROD_ID:   return 32'h04A3_5850;
            IX_RST_STAT:  return 32'h8000_0000;
            IX_INT_CTL2:  return 32'h0008_0000;
            IX_PULL_EN:   return 32'h0000_FFFF;
            IX_INT_CTL:   return 32'h0010_035E;
            IX_CORE_MODE: return 32'hFFF4_FF30;
            IX_SPARE_SW:  return 32'h0000_0003;
            IX_HOST_IF:   return 32'h0000_004E;
            IX_VOLT_LVL:  return 32'h5A00_F3CF;
            IX_SD_UP1:    return 32'hFDC8_0000;
            IX_SD_UP2:    return 32'h5200_B130;
            IX_VSRC:      return 32'h0000_4800;
            IX_SCR_MISC:  return 32'h0000_0008;
            default:      return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/gcr_access_check.sv
module gcr_access_check #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 992,
    parameter int WIDE_BASE = 896,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  gcr_pkg::wpol_e    pol,
    output logic              legal,
    output logic              wide,
    output logic              do_write,
    output logic              err
);
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             shape_ok;
    logic             ro_block;

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        in_range = 32'(idx) < NUM_WORDS;
        wide     = (size == 2'd3);
        case (size)
            2'd2:    shape_ok = (addr[1:0] == 2'b00);
            2'd3:    shape_ok = (addr[2:0] == 3'b000)
                                && (32'(idx) >= WIDE_BASE)
                                && (32'(idx) < NUM_WORDS - 1);
            default: shape_ok = 1'b0;
        endcase
        legal    = in_range && shape_ok;
        ro_block = write && !wide && (pol == gcr_pkg::POL_RO);
        do_write = valid && write && legal && !ro_block;
        err      = valid && (!legal || ro_block);
    end

endmodule

// File: rtl/gcr_write_merge.sv
module gcr_write_merge #(
    parameter int DW = 32
) (
    input  gcr_pkg::wpol_e pol,
    input  logic [DW-1:0]  old_val,
    input  logic [DW-1:0]  wr_val,
    output logic [DW-1:0]  new_val
);
    always_comb begin
        case (pol)
            gcr_pkg::POL_W1C: new_val = old_val & ~wr_val;
            gcr_pkg::POL_W1S: new_val = old_val | wr_val;
            gcr_pkg::POL_RO:  new_val = old_val;
            default:          new_val = wr_val;
        endcase
    end

endmodule

// File: rtl/gcr_store.sv
module gcr_store #(
    parameter int NUM_WORDS = 992,
    parameter int IDX_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      rst_pwr,
    input  logic [31:0]      rst_mdis,
    input  logic [31:0]      rst_ctl3,
    input  logic [31:0]      rst_dram,
    input  logic             wr_lo_en,
    input  logic [IDX_W-1:0] wr_lo_idx,
    input  logic [31:0]      wr_lo_data,
    input  logic             wr_hi_en,
    input  logic [IDX_W-1:0] wr_hi_idx,
    input  logic [31:0]      wr_hi_data,
    input  logic [IDX_W-1:0] rd_lo_idx,
    input  logic [IDX_W-1:0] rd_hi_idx,
    output logic [31:0]      rd_lo_data,
    output logic [31:0]      rd_hi_data
);
    logic [31:0] word_q [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[i] <= gcr_pkg::cold_word(i, rst_pwr, rst_mdis, rst_ctl3, rst_dram);
            end else if (wr_lo_en && wr_lo_idx == IDX_W'(i)) begin
                word_q[i] <= wr_lo_data;
            end else if (wr_hi_en && wr_hi_idx == IDX_W'(i)) begin
                word_q[i] <= wr_hi_data;
            end
        end
    end

    always_comb begin
        rd_lo_data = (32'(rd_lo_idx) < NUM_WORDS) ? word_q[rd_lo_idx] : 32'h0;
        rd_hi_data = (32'(rd_hi_idx) < NUM_WORDS) ? word_q[rd_hi_idx] : 32'h0;
    end

    // R4: a clear-on-one word never gains a bit
    a_r4_w1c_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((word_q[gcr_pkg::IX_RST_STAT] & ~$past(word_q[gcr_pkg::IX_RST_STAT])) == 32'h0));

    // R5: a set-on-one word never loses a bit
    a_r5_w1s_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((word_q[gcr_pkg::IX_MOD_DIS] & $past(word_q[gcr_pkg::IX_MOD_DIS]))
                          == $past(word_q[gcr_pkg::IX_MOD_DIS])));

    // R3: read-only words hold their reset value
    a_r3_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(word_q[gcr_pkg::IX_PROD_ID]) && $stable(word_q[gcr_pkg::IX_STRAPS])));

endmodule

// File: rtl/gcr_regbank.sv
module gcr_regbank #(
    parameter int              ADDR_W     = 12,
    parameter int              NUM_WORDS  = 992,
    parameter int              WIDE_BASE  = 896,
    parameter longint unsigned DRAM_BYTES = 64'h0000_0000_8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic [31:0]       strap_pwr,
    input  logic [31:0]       strap_mdis,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);
    import gcr_pkg::*;

    localparam int              IDX_W     = ADDR_W - 2;
    localparam longint unsigned DRAM_MIN  = 64'd134217728;
    localparam longint unsigned DRAM_MAX  = 64'd2147483648;
    localparam bit              DRAM_OK   = (DRAM_BYTES >= DRAM_MIN) && (DRAM_BYTES <= DRAM_MAX)
                                            && ((DRAM_BYTES & (DRAM_BYTES - 64'd1)) == 64'd0);
    localparam int              DRAM_CODE = $clog2(DRAM_BYTES) - $clog2(DRAM_MIN);
    localparam logic [31:0]     CTL3_RST  = 32'h0000_1002 | (32'(DRAM_CODE) << 8);
    localparam logic [31:0]     DRAM_LO   = DRAM_BYTES[31:0];

    if (!DRAM_OK) begin : g_bad_dram
        $error("gcr_regbank: DRAM_BYTES must be a power of two from 128 MiB to 2 GiB");
    end

    logic [IDX_W-1:0] idx;
    wpol_e            pol;
    logic             legal, wide, do_write, chk_err;
    logic [31:0]      rd_lo, rd_hi, merged;
    rsp_t             rsp_d, rsp_q;

    always_comb begin
        idx = req_addr[ADDR_W-1:2];
        pol = word_policy(32'(idx));
    end

    gcr_access_check #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WIDE_BASE(WIDE_BASE)
    ) u_check (
        .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
        .pol(pol), .legal(legal), .wide(wide), .do_write(do_write), .err(chk_err)
    );

    gcr_write_merge #(.DW(32)) u_merge (
        .pol(pol), .old_val(rd_lo), .wr_val(req_wdata[31:0]), .new_val(merged)
    );

    gcr_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rst_pwr(strap_pwr), .rst_mdis(strap_mdis), .rst_ctl3(CTL3_RST), .rst_dram(DRAM_LO),
        .wr_lo_en(do_write), .wr_lo_idx(idx),
        .wr_lo_data(wide ? req_wdata[31:0] : merged),
        .wr_hi_en(do_write && wide), .wr_hi_idx(idx + IDX_W'(1)),
        .wr_hi_data(req_wdata[63:32]),
        .rd_lo_idx(idx), .rd_hi_idx(idx + IDX_W'(1)),
        .rd_lo_data(rd_lo), .rd_hi_data(rd_hi)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.vld   = req_valid;
        rsp_d.err   = chk_err;
        if (req_valid && !req_write && legal) begin
            rsp_d.rdata = {wide ? rd_hi : 32'h0, rd_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R13: a response follows each request by exactly one cycle
    a_r13_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r13_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: out-of-range accesses error out and read as zero
    a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_addr[ADDR_W-1:2]) >= NUM_WORDS) |=> (rsp_err && rsp_rdata == 64'h0));

    // R9: sub-word accesses are always rejected
    a_r9_narrow_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size < 2'd2) |=> rsp_err);

endmodule

// File: tb/gcr_regbank_bench.sv
module gcr_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic [31:0] strap_pwr, strap_mdis;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit [31:0] mdl [1024];
    bit        exp_vld;
    bit        exp_err;
    bit [63:0] exp_rd;
    string     exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcr_regbank u_gcr_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .strap_pwr(strap_pwr), .strap_mdis(strap_mdis),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) mdl[i] = 32'h0;
        mdl[12'h000 >> 2] = 32'h04A3_5850;
        mdl[12'h004 >> 2] = strap_pwr;
        mdl[12'h014 >> 2] = 32'h0000_FFFF;
        mdl[12'h034 >> 2] = 32'hFFF4_FF30;
        mdl[12'h038 >> 2] = 32'h0000_0003;
        mdl[12'h03C >> 2] = 32'h0010_035E;
        mdl[12'h050 >> 2] = 32'h0000_004E;
        mdl[12'h060 >> 2] = 32'h0008_0000;
        mdl[12'h06C >> 2] = 32'h8000_0000;
        mdl[12'h07C >> 2] = strap_mdis;
        mdl[12'h084 >> 2] = 32'h8000_0000;
        mdl[12'h098 >> 2] = 32'h5A00_F3CF;
        mdl[12'h09C >> 2] = 32'h0000_1402;
        mdl[12'h0B4 >> 2] = 32'hFDC8_0000;
        mdl[12'h0B8 >> 2] = 32'h5200_B130;
        mdl[12'h0E8 >> 2] = 32'h0000_4800;
        mdl[12'h13C >> 2] = 32'h0000_0008;
        for (int a = 12'h140; a <= 12'h148; a += 4) mdl[a >> 2] = 32'h0347_30E4;
        for (int a = 12'hF00; a <= 12'hF7C; a += 4) mdl[a >> 2] = 32'h1;
    endtask

    task automatic compare();
        n_checks++;
        if (rsp_valid !== exp_vld || rsp_err !== exp_err || rsp_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b err=%0b rd=%h, expected vld=%0b err=%0b rd=%h",
                     exp_tag, rsp_valid, rsp_err, rsp_rdata, exp_vld, exp_err, exp_rd);
        end
    endtask

    // one bus cycle: check last cycle's response, then issue the next request
    task automatic step(input bit v, input bit w, input int addr, input int sz,
                        input bit [63:0] wd, input string tag);
        int  idx;
        bit  shape, legal, ro;
        @(negedge clk);
        compare();
        idx   = addr >> 2;
        if (sz == 2)      shape = (addr % 4 == 0);
        else if (sz == 3) shape = (addr % 8 == 0) && addr >= 'hE00 && addr < 'hF7C;
        else              shape = 1'b0;
        legal = (idx < 992) && shape;
        ro    = (idx == 0) || (idx == 1) || (idx == 16);
        exp_vld = v; exp_err = 1'b0; exp_rd = 64'h0; exp_tag = tag;
        if (v) begin
            if (!legal) exp_err = 1'b1;
            else if (w) begin
                if (sz == 3) begin
                    mdl[idx] = wd[31:0]; mdl[idx+1] = wd[63:32];
                end else if (ro) exp_err = 1'b1;
                else if (idx == 27 || idx == 53) mdl[idx] = mdl[idx] & ~wd[31:0];
                else if (idx == 28 || idx == 31) mdl[idx] = mdl[idx] | wd[31:0];
                else mdl[idx] = wd[31:0];
            end else begin
                exp_rd = (sz == 3) ? {mdl[idx+1], mdl[idx]} : {32'h0, mdl[idx]};
            end
        end
        req_valid = v; req_write = w; req_addr = 12'(addr);
        req_size = 2'(sz); req_wdata = wd;
    endtask

    task automatic rd(input int a, input string tag);  step(1, 0, a, 2, 64'h0, tag); endtask
    task automatic wr(input int a, input bit [31:0] d, input string tag); step(1, 1, a, 2, {32'h0, d}, tag); endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = 2'd2; req_wdata = '0;
        strap_pwr = 32'hA5A5_0F0F; strap_mdis = 32'h0000_0300;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        exp_vld = 1'b0; exp_err = 1'b0; exp_rd = 64'h0; exp_tag = "R1 reset";
        // R1 cold values
        rd('h000, "R1"); rd('h014, "R1"); rd('h06C, "R1"); rd('h060, "R1");
        rd('h13C, "R1"); rd('h140, "R1"); rd('h144, "R1"); rd('h148, "R1");
        // R10 straps, R11 DRAM code
        rd('h004, "R10"); rd('h07C, "R10");
        rd('h09C, "R11"); rd('h084, "R11");
        // R12 semaphores and scratch
        rd('hF00, "R12"); rd('hF7C, "R12"); rd('hE00, "R12"); rd('hEFC, "R12");
        // R6 plain words, back-to-back with R13
        wr('h080, 32'hDEAD_BEEF, "R6"); rd('h080, "R13");
        wr('h03C, 32'h1234_5678, "R6"); rd('h03C, "R6");
        // R3 read-only
        wr('h000, 32'hFFFF_FFFF, "R3"); rd('h000, "R3");
        wr('h004, 32'h0, "R3"); rd('h004, "R3");
        wr('h040, 32'hFFFF_FFFF, "R3"); rd('h040, "R3");
        // R4 clear-on-one
        wr('h06C, 32'h0, "R4"); rd('h06C, "R4");
        wr('h06C, 32'h8000_0000, "R4"); rd('h06C, "R4");
        wr('h0D4, 32'hFFFF_FFFF, "R4"); rd('h0D4, "R4");
        // R5 set-on-one
        wr('h070, 32'h5, "R5"); wr('h070, 32'h2, "R5"); rd('h070, "R5");
        wr('h07C, 32'h0, "R5"); wr('h07C, 32'h1, "R5"); rd('h07C, "R5");
        // R7 wide window
        step(1, 1, 'hE00, 3, 64'h1122_3344_5566_7788, "R7");
        rd('hE00, "R7"); rd('hE04, "R7");
        step(1, 0, 'hE00, 3, 64'h0, "R7");
        step(1, 0, 'hF78, 3, 64'h0, "R7");
        step(1, 1, 'hF78, 3, 64'hCAFE_0000_0000_BABE, "R7");
        rd('hF78, "R7"); rd('hF7C, "R7");
        // R8 rejected wide
        step(1, 0, 'hF7C, 3, 64'h0, "R8");
        step(1, 1, 'hE04, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        rd('hE04, "R8"); rd('hE08, "R8");
        step(1, 1, 'hDF8, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        rd('hDF8, "R8");
        step(1, 0, 'h080, 3, 64'h0, "R8");
        // R9 narrow and unaligned
        step(1, 1, 'h080, 0, 64'h0, "R9");
        step(1, 1, 'h080, 1, 64'h0, "R9");
        step(1, 1, 'h082, 2, 64'h0, "R9");
        step(1, 0, 'h081, 2, 64'h0, "R9");
        rd('h080, "R9");
        // R2 out of range
        rd('hF80, "R2");
        wr('hFFC, 32'hFFFF_FFFF, "R2");
        rd('hFFC, "R2");
        rd('hF7C, "R2");
        // R13 idle cycles
        step(0, 0, 0, 2, 64'h0, "R13");
        step(0, 1, 'h080, 2, 64'h1, "R13");
        rd('h080, "R13");
        step(0, 0, 0, 2, 64'h0, "R13");
        step(0, 0, 0, 2, 64'h0, "R13");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R13: watchdog expired, got no end, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule